// File: doc/BRIEF.md
# PHY Parameter Initialization Sequencer

This block brings a serial-link PHY out of reset without software. Once it sees a start pulse, it programs a short list of PHY tuning parameters and then releases the PHY reset. It reaches the PHY only through a register bus. On that bus the PHY exposes three things:

- a clock-control register;
- a 32-bit indirect test-port pair, made of a frame register that the block writes and a status register that it reads;
- a reset-control register.

Each parameter is changed by read-modify-write through the test port. The old 8-bit value is fetched with a read-request frame. The new bits are merged under a mask. The merged frame is then written three times, with the write-enable flag pulsed in the middle write. A final dummy read-request closes the update. Every frame write is followed by two status reads before any other test-port access.

A strap input selects one or two PHY instances. The second instance sits in the upper half of both test-port words. Between the parameter phase and the reset release, the block waits for a parameterised number of idle cycles. When the last write completes it pulses `done`.

Top module: `phy_init_seq`

## Requirements
- R1: Out of reset, `busy` and `done` are low and neither `busWe` nor `busRe` is asserted until a start pulse arrives.
- R2: A run begins by reading the clock-control register (offset 0x0000) and writing it back with bits 11:9 set to 1 and every other bit unchanged.
- R3: A test-port frame written to offset 0x2000 carries data in bits 13:6, the parameter address in bits 5:1 and the write-enable flag in bit 0. All other bits are zero for PHY 0.
- R4: Each parameter update is exactly 17 accesses in this order. Every frame write is followed by two status reads (offset 0x2004).
  - Read-request frame (data 1, write-enable 0), then three status reads; the third read supplies the old value.
  - Merged frame with write-enable 0, then 1, then 0, each followed by two reads.
  - Read-request frame, then three reads.
- R5: The old value is taken from status bits 7:0 for PHY 0 and bits 23:16 for PHY 1. The merged data is (old AND NOT mask) OR (value AND mask).
- R6: Four parameters are updated per PHY, in this order (address, mask, value):
  - address 0, mask 0x08, value 0x08;
  - address 6, mask 0x3F, value 0x00;
  - address 26, mask 0xF0, value 0x50;
  - address 28, mask 0x0C, value 0x00.
- R7: With `dualPhy` high at start, the full list runs for PHY 0 and then for PHY 1. PHY 1 frames are the PHY 0 layout shifted left by 16. With `dualPhy` low, only PHY 0 is touched.
- R8: Between the last parameter access and the reset-register read, the bus is idle for exactly `SETTLE_CYCLES` cycles.
- R9: The run ends by reading the reset register (offset 0x200C) and writing it back with bits 8 and 0 set and all other bits unchanged.
- R10: `done` is high for exactly one cycle, the cycle after the reset-register write completes. `busy` is low in that cycle.
- R11: A start pulse while `busy` is high is ignored. The run in progress is neither restarted nor lengthened.
- R12: An access holds address, write data and strobes stable until `busReady` is seen. Read data is taken only in the `busReady` cycle, so any number of wait states is tolerated.
- R13: `busWe` and `busRe` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a bring-up run |
| dualPhy | input | 1 | Strap: program two PHY instances, sampled at start |
| busAddr | output | ADDR_W | Register-bus address |
| busWdata | output | 32 | Register-bus write data |
| busWe | output | 1 | Write strobe, held until ready |
| busRe | output | 1 | Read strobe, held until ready |
| busRdata | input | 32 | Read data, valid with busReady |
| busReady | input | 1 | Access completes in this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Every cycle, the assertions check the bus handshake rules: strobes are exclusive, and a stalled access holds stable. They also check the field shape of every clock-control, test-port and reset write, and that `done` is a single pulse following a completed write. The exact access order, the merged data values, the lane shifting of the second PHY, the idle gap length and the discarding of extra start pulses can only be shown by the bench. It compares each bus access against an independently built expected list, running against a PHY register model with varied wait states and initial contents.

// File: rtl/phy_init_pkg.sv
`timescale 1ns/1ps
package phy_init_pkg;
  localparam int BUS_W        = 32;
  localparam int LANE_SHIFT   = 16;
  localparam int NUM_PARAMS   = 4;
  localparam int PIDX_W       = $clog2(NUM_PARAMS);
  localparam int STEPS        = 17;
  localparam int STEP_W       = $clog2(STEPS);
  localparam int PORT_SEL_LSB = 9;
  localparam int PORT_SEL_W   = 3;
  localparam int PORT_SEL_VAL = 1;
  localparam int RST_MANUAL_BIT  = 8;
  localparam int RST_RELEASE_BIT = 0;

  typedef enum logic [2:0] {
    SEL_CLK,
    SEL_TESTI_REQ,
    SEL_TESTI_MRG,
    SEL_TESTO,
    SEL_RST
  } accSel_t;

  typedef struct packed {
    logic              rdReq;
    logic              wrReq;
    accSel_t           sel;
    logic              frameWe;
    logic              capOld;
    logic              capClk;
    logic              capRst;
    logic [PIDX_W-1:0] paramIdx;
    logic              phySel;
  } dpCtrl_t;

  function automatic logic [4:0] paramAddr(input logic [PIDX_W-1:0] idx);
    case (idx)
      2'd0:    return 5'd0;
      2'd1:    return 5'd6;
      2'd2:    return 5'd26;
      default: return 5'd28;
    endcase
  endfunction

  function automatic logic [7:0] paramMask(input logic [PIDX_W-1:0] idx);
    case (idx)
      2'd0:    return 8'h08;
      2'd1:    return 8'h3F;
      2'd2:    return 8'hF0;
      default: return 8'h0C;
    endcase
  endfunction

  function automatic logic [7:0] paramValue(input logic [PIDX_W-1:0] idx);
    case (idx)
      2'd0:    return 8'h08;
      2'd2:    return 8'h50;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] packFrame(input logic [7:0] dat, input logic [4:0] adr, input logic we);
    return {2'b00, dat, adr, we};
  endfunction
endpackage

// File: rtl/phy_init_ctrl.sv
`timescale 1ns/1ps
module phy_init_ctrl
  import phy_init_pkg::*;
#(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    dualPhy,
  input  logic    busReady,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0]  SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(STEPS - 1);
  localparam logic [STEP_W-1:0] CAP_STEP    = STEP_W'(3);
  localparam logic [PIDX_W-1:0] LAST_PARAM  = PIDX_W'(NUM_PARAMS - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLK_RD, ST_CLK_WR, ST_PARAM,
    ST_SETTLE, ST_RST_RD, ST_RST_WR, ST_DONE
  } state_t;

  state_t            state;
  logic [STEP_W-1:0] stepIdx;
  logic [PIDX_W-1:0] paramIdx;
  logic              phySel;
  logic              dualLatched;
  logic [CNT_W-1:0]  settleCnt;
  logic              accept;

  // steps that write a frame; all others read the status word
  function automatic logic stepWrites(input logic [STEP_W-1:0] s);
    return (s == 5'd0) || (s == 5'd4) || (s == 5'd7) || (s == 5'd10) || (s == 5'd13);
  endfunction

  always_comb begin
    ctrl          = '0;
    ctrl.sel      = SEL_CLK;
    ctrl.paramIdx = paramIdx;
    ctrl.phySel   = phySel;
    case (state)
      ST_CLK_RD: begin
        ctrl.rdReq  = 1'b1;
        ctrl.capClk = busReady;
      end
      ST_CLK_WR: ctrl.wrReq = 1'b1;
      ST_PARAM: begin
        if (stepWrites(stepIdx)) begin
          ctrl.wrReq   = 1'b1;
          ctrl.sel     = ((stepIdx == 5'd0) || (stepIdx == 5'd13)) ? SEL_TESTI_REQ : SEL_TESTI_MRG;
          ctrl.frameWe = (stepIdx == 5'd7);
        end else begin
          ctrl.rdReq  = 1'b1;
          ctrl.sel    = SEL_TESTO;
          ctrl.capOld = (stepIdx == CAP_STEP) && busReady;
        end
      end
      ST_RST_RD: begin
        ctrl.rdReq  = 1'b1;
        ctrl.sel    = SEL_RST;
        ctrl.capRst = busReady;
      end
      ST_RST_WR: begin
        ctrl.wrReq = 1'b1;
        ctrl.sel   = SEL_RST;
      end
      default: ;
    endcase
  end

  assign accept = busReady && (ctrl.rdReq || ctrl.wrReq);
  assign busy   = (state != ST_IDLE) && (state != ST_DONE);
  assign done   = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      stepIdx     <= '0;
      paramIdx    <= '0;
      phySel      <= 1'b0;
      dualLatched <= 1'b0;
      settleCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state       <= ST_CLK_RD;
          dualLatched <= dualPhy;
          stepIdx     <= '0;
          paramIdx    <= '0;
          phySel      <= 1'b0;
        end
        ST_CLK_RD: if (accept) state <= ST_CLK_WR;
        ST_CLK_WR: if (accept) state <= ST_PARAM;
        ST_PARAM: if (accept) begin
          if (stepIdx == LAST_STEP) begin
            stepIdx <= '0;
            if (paramIdx == LAST_PARAM) begin
              paramIdx <= '0;
              if (!phySel && dualLatched) begin
                phySel <= 1'b1;
              end else begin
                state     <= ST_SETTLE;
                settleCnt <= SETTLE_LOAD;
              end
            end else begin
              paramIdx <= paramIdx + 1'b1;
            end
          end else begin
            stepIdx <= stepIdx + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settleCnt == '0) state <= ST_RST_RD;
          else settleCnt <= settleCnt - 1'b1;
        end
        ST_RST_RD: if (accept) state <= ST_RST_WR;
        ST_RST_WR: if (accept) state <= ST_DONE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_init_dp.sv
`timescale 1ns/1ps
module phy_init_dp
  import phy_init_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLK_CTRL_ADDR = 16'h0000,
  parameter logic [ADDR_W-1:0] TESTI_ADDR    = 16'h2000,
  parameter logic [ADDR_W-1:0] TESTO_ADDR    = 16'h2004,
  parameter logic [ADDR_W-1:0] RST_CTRL_ADDR = 16'h200C
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [BUS_W-1:0]  busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BUS_W-1:0]  busWdata,
  output logic              busWe,
  output logic              busRe
);
  localparam logic [BUS_W-1:0] PORT_SEL_MASK = BUS_W'((1 << PORT_SEL_W) - 1) << PORT_SEL_LSB;
  localparam logic [BUS_W-1:0] PORT_SEL_SET  = BUS_W'(PORT_SEL_VAL) << PORT_SEL_LSB;
  localparam logic [BUS_W-1:0] RST_SET = (BUS_W'(1) << RST_MANUAL_BIT) | (BUS_W'(1) << RST_RELEASE_BIT);

  logic [7:0]       oldVal;
  logic [BUS_W-1:0] clkShadow;
  logic [BUS_W-1:0] rstShadow;
  logic [BUS_W-1:0] laneRd;
  logic [4:0]       fieldAddr;
  logic [7:0]       fieldMask;
  logic [7:0]       fieldValue;
  logic [7:0]       merged;
  logic [15:0]      reqFrame;
  logic [15:0]      mrgFrame;
  logic [BUS_W-1:0] reqWord;
  logic [BUS_W-1:0] mrgWord;

  always_comb begin
    laneRd     = ctrl.phySel ? (busRdata >> LANE_SHIFT) : busRdata;
    fieldAddr  = paramAddr(ctrl.paramIdx);
    fieldMask  = paramMask(ctrl.paramIdx);
    fieldValue = paramValue(ctrl.paramIdx);
    merged     = (oldVal & ~fieldMask) | (fieldValue & fieldMask);
    reqFrame   = packFrame(8'd1, fieldAddr, 1'b0);
    mrgFrame   = packFrame(merged, fieldAddr, ctrl.frameWe);
    reqWord    = ctrl.phySel ? (BUS_W'(reqFrame) << LANE_SHIFT) : BUS_W'(reqFrame);
    mrgWord    = ctrl.phySel ? (BUS_W'(mrgFrame) << LANE_SHIFT) : BUS_W'(mrgFrame);
  end

  always_comb begin
    busWe    = ctrl.wrReq;
    busRe    = ctrl.rdReq;
    busAddr  = CLK_CTRL_ADDR;
    busWdata = '0;
    case (ctrl.sel)
      SEL_CLK: begin
        busAddr  = CLK_CTRL_ADDR;
        busWdata = (clkShadow & ~PORT_SEL_MASK) | PORT_SEL_SET;
      end
      SEL_TESTI_REQ: begin
        busAddr  = TESTI_ADDR;
        busWdata = reqWord;
      end
      SEL_TESTI_MRG: begin
        busAddr  = TESTI_ADDR;
        busWdata = mrgWord;
      end
      SEL_TESTO: busAddr = TESTO_ADDR;
      SEL_RST: begin
        busAddr  = RST_CTRL_ADDR;
        busWdata = rstShadow | RST_SET;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oldVal    <= '0;
      clkShadow <= '0;
      rstShadow <= '0;
    end else begin
      if (ctrl.capOld) oldVal    <= laneRd[7:0];
      if (ctrl.capClk) clkShadow <= busRdata;
      if (ctrl.capRst) rstShadow <= busRdata;
    end
  end
endmodule

// File: rtl/phy_init_seq.sv
`timescale 1ns/1ps
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETTLE_CYCLES = 64,
  parameter logic [ADDR_W-1:0] CLK_CTRL_ADDR = 16'h0000,
  parameter logic [ADDR_W-1:0] TESTI_ADDR    = 16'h2000,
  parameter logic [ADDR_W-1:0] TESTO_ADDR    = 16'h2004,
  parameter logic [ADDR_W-1:0] RST_CTRL_ADDR = 16'h200C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dualPhy,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  output logic              busWe,
  output logic              busRe,
  input  logic [31:0]       busRdata,
  input  logic              busReady,
  output logic              busy,
  output logic              done
);
  dpCtrl_t ctrl;

  phy_init_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dualPhy(dualPhy),
    .busReady(busReady), .ctrl(ctrl), .busy(busy), .done(done)
  );

  phy_init_dp #(
    .ADDR_W(ADDR_W), .CLK_CTRL_ADDR(CLK_CTRL_ADDR), .TESTI_ADDR(TESTI_ADDR),
    .TESTO_ADDR(TESTO_ADDR), .RST_CTRL_ADDR(RST_CTRL_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe)
  );
endmodule

// File: rtl/phy_init_seq_chk.sv
`timescale 1ns/1ps
module phy_init_seq_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLK_CTRL_ADDR = 16'h0000,
  parameter logic [ADDR_W-1:0] TESTI_ADDR    = 16'h2000,
  parameter logic [ADDR_W-1:0] RST_CTRL_ADDR = 16'h200C
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busWe,
  input logic              busRe,
  input logic              busReady,
  input logic              busy,
  input logic              done
);
  // R13: strobes exclusive
  a_r13_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busWe, busRe}));

  // R12: a stalled access holds still
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    ((busWe || busRe) && !busReady) |=>
      ($stable(busAddr) && $stable(busWdata) && $stable(busWe) && $stable(busRe)));

  // R1: no traffic while not busy
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busWe && !busRe));

  // R10: done is one cycle, following a completed write
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_done_after_wr: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busWe && busReady) && !busy));

  // R11: a run is never cut short by a start pulse
  a_r11_run_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  // R2: port-select field written as 1
  a_r2_port_sel: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == CLK_CTRL_ADDR) |-> (busWdata[11:9] == 3'd1));

  // R3 / R7: frame occupies exactly one lane, spare bits clear
  a_r3_frame_shape: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == TESTI_ADDR) |->
      (busWdata[31:30] == 2'b00 && busWdata[15:14] == 2'b00 &&
       (busWdata[31:16] == 16'h0 || busWdata[15:0] == 16'h0)));

  // R9: reset release bits set
  a_r9_rst_bits: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == RST_CTRL_ADDR) |-> (busWdata[8] && busWdata[0]));
endmodule

bind phy_init_seq phy_init_seq_chk #(
  .ADDR_W(ADDR_W), .CLK_CTRL_ADDR(CLK_CTRL_ADDR),
  .TESTI_ADDR(TESTI_ADDR), .RST_CTRL_ADDR(RST_CTRL_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busAddr(busAddr), .busWdata(busWdata),
  .busWe(busWe), .busRe(busRe), .busReady(busReady), .busy(busy), .done(done)
);

// File: tb/phy_init_seq_tb.sv
`timescale 1ns/1ps
module phy_init_seq_tb;
  localparam int SETTLE = 64;
  localparam logic [15:0] A_CLK = 16'h0000;
  localparam logic [15:0] A_TI  = 16'h2000;
  localparam logic [15:0] A_TO  = 16'h2004;
  localparam logic [15:0] A_RST = 16'h200C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dualPhy = 1'b0;
  logic [15:0] busAddr;
  logic [31:0] busWdata;
  logic        busWe, busRe;
  logic [31:0] busRdata = '0;
  logic        busReady = 1'b0;
  logic        busy, done;

  always #2 clk = ~clk;

  phy_init_seq #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dualPhy(dualPhy),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .busRdata(busRdata), .busReady(busReady), .busy(busy), .done(done)
  );

  typedef struct {
    bit          isWr;
    logic [15:0] addr;
    logic [31:0] data;
    string       req;
  } item_t;

  item_t       expQ[$];
  int          checks = 0;
  int          fails = 0;
  logic [7:0]  phyReg[2][32];
  logic [4:0]  laneAddr[2];
  logic [31:0] clkReg, rstReg;
  int          waitMode = 0;
  int          waitLeft = 0;
  int          lfsr = 7;
  int          idleRun = 0;
  bit          expDone = 0;
  int          doneCount = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] frame(input logic [7:0] d, input logic [4:0] a, input bit we, input int lane);
    logic [31:0] w;
    w = {18'b0, d, a, we};
    return lane != 0 ? w << 16 : w;
  endfunction

  function automatic int pAddr(input int k);
    return k == 0 ? 0 : k == 1 ? 6 : k == 2 ? 26 : 28;
  endfunction
  function automatic logic [7:0] pMask(input int k);
    return k == 0 ? 8'h08 : k == 1 ? 8'h3F : k == 2 ? 8'hF0 : 8'h0C;
  endfunction
  function automatic logic [7:0] pVal(input int k);
    return k == 0 ? 8'h08 : k == 2 ? 8'h50 : 8'h00;
  endfunction

  task automatic push(input bit w, input logic [15:0] a, input logic [31:0] d, input string r);
    item_t it;
    it.isWr = w; it.addr = a; it.data = d; it.req = r;
    expQ.push_back(it);
  endtask

  task automatic pushRds(input int n, input string r);
    for (int i = 0; i < n; i++) push(0, A_TO, '0, r);
  endtask

  // driver: expected access list for one run (R2 R4 R5 R6 R7 R9)
  task automatic pushRun(input bit dual);
    push(0, A_CLK, '0, "R2");
    push(1, A_CLK, (clkReg & ~32'h0E00) | 32'h0200, "R2");
    for (int p = 0; p < (dual ? 2 : 1); p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] m;
        string tg;
        tg = (p != 0) ? "R7" : "R3";
        m = (phyReg[p][pAddr(k)] & ~pMask(k)) | (pVal(k) & pMask(k));
        push(1, A_TI, frame(8'd1, 5'(pAddr(k)), 0, p), tg);
        pushRds(3, "R4");
        push(1, A_TI, frame(m, 5'(pAddr(k)), 0, p), "R5");
        pushRds(2, "R4");
        push(1, A_TI, frame(m, 5'(pAddr(k)), 1, p), "R5");
        pushRds(2, "R4");
        push(1, A_TI, frame(m, 5'(pAddr(k)), 0, p), "R5");
        pushRds(2, "R4");
        push(1, A_TI, frame(8'd1, 5'(pAddr(k)), 0, p), tg);
        pushRds(3, "R4");
      end
    end
    push(0, A_RST, '0, "R9");
    push(1, A_RST, rstReg | 32'h0101, "R9");
  endtask

  // slave + monitor: grants accesses and pops the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (expDone || done) check(done === expDone && !busy, "R10", "done pulse", {30'b0, busy, done}, {31'b0, expDone});
      if (done) doneCount++;
      expDone = 0;
      if (!(busWe || busRe)) begin
        busReady = 0;
        idleRun++;
      end else begin
        if (idleRun > 0 && busRe && busAddr == A_RST)
          check(idleRun == SETTLE, "R8", "idle gap", idleRun, SETTLE);
        idleRun = 0;
        if (waitLeft > 0) begin
          busReady = 0;
          waitLeft--;
        end else begin
          item_t it;
          busReady = 1;
          lfsr = (lfsr * 5 + 3) % 17;
          waitLeft = (waitMode != 0) ? lfsr % 3 : 0;
          if (expQ.size() == 0) begin
            check(0, "R4", "unexpected access", {16'h0, busAddr}, 32'h0);
          end else begin
            it = expQ.pop_front();
            check(busWe == it.isWr && busRe == !it.isWr && busAddr == it.addr &&
                  (!it.isWr || busWdata == it.data), it.req, "bus access",
                  it.isWr ? busWdata : {16'h0, busAddr}, it.isWr ? it.data : {16'h0, it.addr});
          end
          if (busWe) begin
            if (busAddr == A_CLK) clkReg = busWdata;
            if (busAddr == A_RST) begin
              rstReg = busWdata;
              expDone = 1;
            end
            if (busAddr == A_TI) begin
              laneAddr[0] = busWdata[5:1];
              if (busWdata[0]) phyReg[0][busWdata[5:1]] = busWdata[13:6];
              laneAddr[1] = busWdata[21:17];
              if (busWdata[16]) phyReg[1][busWdata[21:17]] = busWdata[29:22];
            end
          end else begin
            if (busAddr == A_TO) busRdata = {8'hA5, phyReg[1][laneAddr[1]], 8'h3C, phyReg[0][laneAddr[0]]};
            else if (busAddr == A_CLK) busRdata = clkReg;
            else if (busAddr == A_RST) busRdata = rstReg;
            else busRdata = 32'hDEAD_BEEF;
          end
        end
      end
    end
  end

  task automatic runSeq(input bit dual, input int wm, input logic [7:0] fill0, input logic [7:0] fill1,
                        input logic [31:0] clkInit, input logic [31:0] rstInit, input bit poke);
    logic [7:0] expReg[2][32];
    int cyc;
    for (int a = 0; a < 32; a++) begin
      phyReg[0][a] = fill0 ^ 8'(a);
      phyReg[1][a] = fill1 ^ 8'(a);
    end
    clkReg = clkInit; rstReg = rstInit; waitMode = wm; doneCount = 0;
    expReg = phyReg;
    for (int p = 0; p < (dual ? 2 : 1); p++)
      for (int k = 0; k < 4; k++)
        expReg[p][pAddr(k)] = (phyReg[p][pAddr(k)] & ~pMask(k)) | (pVal(k) & pMask(k));
    pushRun(dual);
    @(negedge clk); dualPhy = dual; start = 1;
    @(negedge clk); start = 0;
    if (poke) begin
      // R11: extra start pulses mid-run
      repeat (20) @(negedge clk);
      start = 1; dualPhy = !dual;
      @(negedge clk); start = 0;
      repeat (150) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    cyc = 0;
    while (doneCount == 0 && cyc < 20000) begin
      @(negedge clk); cyc++;
    end
    repeat (4) @(negedge clk);
    check(doneCount == 1, "R11", "done count", doneCount, 1);
    check(expQ.size() == 0, "R4", "accesses left", expQ.size(), 0);
    expQ.delete();
    check(clkReg == ((clkInit & ~32'h0E00) | 32'h0200), "R2", "clock ctrl", clkReg, (clkInit & ~32'h0E00) | 32'h0200);
    check(rstReg == (rstInit | 32'h0101), "R9", "reset reg", rstReg, rstInit | 32'h0101);
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 4; k++)
        check(phyReg[p][pAddr(k)] == expReg[p][pAddr(k)], (p != 0) ? "R7" : "R6",
              "phy param", phyReg[p][pAddr(k)], expReg[p][pAddr(k)]);
    check(!busy && !busWe && !busRe, "R1", "idle after run", {29'b0, busy, busWe, busRe}, 0);
  endtask

  initial begin
    #(4 * 190000);
    check(0, "R10", "watchdog", 0, 1);
    summary();
  end

  initial begin
    laneAddr[0] = '0; laneAddr[1] = '0;
    clkReg = '0; rstReg = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !busWe && !busRe, "R1", "reset state", {28'b0, busy, done, busWe, busRe}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !busWe && !busRe, "R1", "idle before start", {28'b0, busy, done, busWe, busRe}, 0);
    // single PHY, no wait states, all-ones contents
    runSeq(0, 0, 8'hFF, 8'hFF, 32'hFFFF_FFFF, 32'h0000_0000, 0);
    // single PHY, wait states (R12), all-zero contents
    runSeq(0, 1, 8'h00, 8'h00, 32'h1234_5E5A, 32'hF0F0_0E0E, 0);
    // dual PHY, R7, zero wait
    runSeq(1, 0, 8'hA6, 8'h59, 32'h0000_0C00, 32'h8000_0000, 0);
    // dual PHY with wait states and start pokes (R11, R12)
    runSeq(1, 1, 8'h3C, 8'hC3, 32'hAAAA_AAAA, 32'h5555_5454, 1);
    summary();
  end
endmodule